// File: doc/BRIEF.md
# Private Interrupt Pending and Active State Tracker

This block holds the pending and active state of the 32 banked private interrupts of one processor interface. Interrupt IDs 0 to 15 are software-generated and IDs 16 to 31 belong to peripherals. Every interrupt has an enable bit and a trigger mode, either edge or level. Peripheral lines report assert and deassert events. Software-generated requests arrive as IDs. Software writes 32-bit set-pending and clear-pending masks, and an acknowledge strobe activates one interrupt.

A level-sensitive interrupt normally follows its line. The block also records whether the pending bit was raised by a software set-pending write. While that record is set, an acknowledge or a clear-pending write treats the interrupt as edge-triggered and drops the pending bit. A later line assert or software-generated request removes the record. The block drives the pending and active vectors and a flag that is high when any enabled interrupt is pending and not active.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset, pendingVec, activeVec, all enables and all software-set records are 0, every interrupt is edge-triggered, and anyPending is 0.
- R2: A line event with lineEvtLevel=1 and an ID in 16..31 sets that interrupt's pending bit and clears its software-set record.
- R3: A line event, assert or deassert, whose ID is in 0..15 changes no state.
- R4: A software-generated request with an ID in 0..15 sets that pending bit and clears its software-set record; a request with an ID in 16..31 is ignored.
- R5: Each 1 bit of a set-pending write sets that interrupt's pending bit and its software-set record.
- R6: Each 1 bit of a clear-pending write clears that pending bit if the interrupt is edge-triggered or its software-set record is 1; otherwise pending is unchanged.
- R7: An acknowledge for an ID sets its active bit and clears its pending bit only if the interrupt is edge-triggered or its software-set record is 1.
- R8: A line event with lineEvtLevel=0 and an ID in 16..31 clears pending only if the interrupt is level-sensitive; on an edge-triggered interrupt it has no effect.
- R9: A deactivate strobe clears that active bit. When acknowledge and deactivate target the same ID in one cycle, the interrupt ends the cycle active.
- R10: Events that meet on one interrupt in one cycle act in this order, and the later one wins: acknowledge, clear-pending, set-pending, then the line or software-generated event.
- R11: anyPending is 1 exactly when some interrupt has pending=1, enable=1 and active=0.
- R12: A config write with cfgWrAddr=0 loads the 32 enable bits. A write with cfgWrAddr=1 loads the trigger modes, where bit value 1 means level-sensitive. Trigger bits 0..15 always stay edge-triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineEvtValid | input | 1 | Peripheral line event strobe |
| lineEvtId | input | 5 | Line event interrupt ID |
| lineEvtLevel | input | 1 | 1 = line asserted, 0 = line deasserted |
| swReqValid | input | 1 | Software-generated request strobe |
| swReqId | input | 5 | Software-generated request ID |
| setPendValid | input | 1 | Set-pending write strobe |
| setPendMask | input | 32 | Set-pending bit mask |
| clrPendValid | input | 1 | Clear-pending write strobe |
| clrPendMask | input | 32 | Clear-pending bit mask |
| ackValid | input | 1 | Acknowledge/activate strobe |
| ackId | input | 5 | ID to activate |
| deactValid | input | 1 | Deactivate strobe |
| deactId | input | 5 | ID to deactivate |
| cfgWrValid | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 1 | 0 = enable register, 1 = trigger register |
| cfgWrData | input | 32 | Configuration write data |
| pendingVec | output | 32 | Pending bit of each interrupt |
| activeVec | output | 32 | Active bit of each interrupt |
| anyPending | output | 1 | Enabled, pending and not active interrupt exists |

## Verification
Every event is sampled at a rising edge. Its effect shows on pendingVec and activeVec right after that edge, one cycle later. anyPending is decoded from the registered state, so it changes on the same edge as the vectors. A configuration write is registered too, so it acts on events from the next cycle onward. The bench drives each stimulus at a falling edge and samples the outputs at the next falling edge, which is half a cycle after the edge that takes the event.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int IRQ_CNT = 32;
  localparam int SGI_CNT = 16;
  localparam int ID_W    = $clog2(IRQ_CNT);

  typedef logic [IRQ_CNT-1:0] irqVec_t;

  // Per-interrupt strobes from control to datapath
  typedef struct packed {
    irqVec_t actM;
    irqVec_t deactM;
    irqVec_t clrM;
    irqVec_t setM;
    irqVec_t lineSetM;
    irqVec_t lineClrM;
    irqVec_t sgiM;
    logic    cfgEnWr;
    logic    cfgTrigWr;
    irqVec_t cfgData;
  } strobe_t;
endpackage

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
(
  input  logic            lineEvtValid,
  input  logic [ID_W-1:0] lineEvtId,
  input  logic            lineEvtLevel,
  input  logic            swReqValid,
  input  logic [ID_W-1:0] swReqId,
  input  logic            setPendValid,
  input  irqVec_t         setPendMask,
  input  logic            clrPendValid,
  input  irqVec_t         clrPendMask,
  input  logic            ackValid,
  input  logic [ID_W-1:0] ackId,
  input  logic            deactValid,
  input  logic [ID_W-1:0] deactId,
  input  logic            cfgWrValid,
  input  logic            cfgWrAddr,
  input  irqVec_t         cfgWrData,
  output strobe_t         strobes
);
  irqVec_t actHit, deactHit, lineUpHit, lineDnHit, sgiHit;

  // ID decode; the range rules for line and software events live here
  for (genvar i = 0; i < IRQ_CNT; i++) begin : g_dec
    localparam bit IS_PERIPH = (i >= SGI_CNT);
    assign actHit[i]    = ackValid   && (ackId   == ID_W'(i));
    assign deactHit[i]  = deactValid && (deactId == ID_W'(i));
    assign lineUpHit[i] = IS_PERIPH && lineEvtValid && lineEvtLevel
                          && (lineEvtId == ID_W'(i));
    assign lineDnHit[i] = IS_PERIPH && lineEvtValid && !lineEvtLevel
                          && (lineEvtId == ID_W'(i));
    assign sgiHit[i]    = !IS_PERIPH && swReqValid && (swReqId == ID_W'(i));
  end

  always_comb begin
    strobes.actM      = actHit;
    strobes.deactM    = deactHit;
    strobes.clrM      = clrPendValid ? clrPendMask : '0;
    strobes.setM      = setPendValid ? setPendMask : '0;
    strobes.lineSetM  = lineUpHit;
    strobes.lineClrM  = lineDnHit;
    strobes.sgiM      = sgiHit;
    strobes.cfgEnWr   = cfgWrValid && !cfgWrAddr;
    strobes.cfgTrigWr = cfgWrValid &&  cfgWrAddr;
    strobes.cfgData   = cfgWrData;
  end
endmodule

// File: rtl/irq_pend_dp.sv
module irq_pend_dp
  import irq_pend_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  output irqVec_t pendingVec,
  output irqVec_t activeVec,
  output logic    anyPending
);
  localparam irqVec_t PERIPH_MASK = {{(IRQ_CNT-SGI_CNT){1'b1}}, {SGI_CNT{1'b0}}};

  irqVec_t pendQ, actQ, enQ, trigLvlQ, swSetQ;
  irqVec_t pendD, actD, swSetD, edgeLike, fresh;

  // Acknowledge, clear, set, then line/software events; later steps win
  always_comb begin
    edgeLike = ~trigLvlQ | swSetQ;
    fresh    = strobes.lineSetM | strobes.sgiM;
    pendD    = pendQ & ~(strobes.actM & edgeLike);
    pendD    = pendD & ~(strobes.clrM & edgeLike);
    pendD    = pendD | strobes.setM;
    swSetD   = swSetQ | strobes.setM;
    pendD    = pendD | fresh;
    swSetD   = swSetD & ~fresh;
    pendD    = pendD & ~(strobes.lineClrM & trigLvlQ);
    actD     = (actQ & ~strobes.deactM) | strobes.actM;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      actQ     <= '0;
      enQ      <= '0;
      trigLvlQ <= '0;
      swSetQ   <= '0;
    end else begin
      pendQ  <= pendD;
      actQ   <= actD;
      swSetQ <= swSetD;
      if (strobes.cfgEnWr)   enQ      <= strobes.cfgData;
      if (strobes.cfgTrigWr) trigLvlQ <= strobes.cfgData & PERIPH_MASK;
    end
  end

  assign pendingVec = pendQ;
  assign activeVec  = actQ;
  assign anyPending = |(pendQ & enQ & ~actQ);
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_pend_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineEvtValid,
  input  logic [ID_W-1:0] lineEvtId,
  input  logic            lineEvtLevel,
  input  logic            swReqValid,
  input  logic [ID_W-1:0] swReqId,
  input  logic            setPendValid,
  input  logic [IRQ_CNT-1:0] setPendMask,
  input  logic            clrPendValid,
  input  logic [IRQ_CNT-1:0] clrPendMask,
  input  logic            ackValid,
  input  logic [ID_W-1:0] ackId,
  input  logic            deactValid,
  input  logic [ID_W-1:0] deactId,
  input  logic            cfgWrValid,
  input  logic            cfgWrAddr,
  input  logic [IRQ_CNT-1:0] cfgWrData,
  output logic [IRQ_CNT-1:0] pendingVec,
  output logic [IRQ_CNT-1:0] activeVec,
  output logic            anyPending
);
  strobe_t strobes;

  irq_pend_ctrl u_ctrl (
    .lineEvtValid(lineEvtValid), .lineEvtId(lineEvtId), .lineEvtLevel(lineEvtLevel),
    .swReqValid(swReqValid), .swReqId(swReqId),
    .setPendValid(setPendValid), .setPendMask(setPendMask),
    .clrPendValid(clrPendValid), .clrPendMask(clrPendMask),
    .ackValid(ackValid), .ackId(ackId),
    .deactValid(deactValid), .deactId(deactId),
    .cfgWrValid(cfgWrValid), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .strobes(strobes)
  );

  irq_pend_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pendingVec(pendingVec), .activeVec(activeVec), .anyPending(anyPending)
  );
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            lineEvtValid,
  input logic [ID_W-1:0] lineEvtId,
  input logic            lineEvtLevel,
  input logic            swReqValid,
  input logic [ID_W-1:0] swReqId,
  input logic            setPendValid,
  input logic [IRQ_CNT-1:0] setPendMask,
  input logic            ackValid,
  input logic [ID_W-1:0] ackId,
  input logic            deactValid,
  input logic [ID_W-1:0] deactId,
  input logic [IRQ_CNT-1:0] pendingVec,
  input logic [IRQ_CNT-1:0] activeVec,
  input logic            anyPending
);
  assert_line_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lineEvtValid && lineEvtLevel && (int'(lineEvtId) >= SGI_CNT))
      |=> pendingVec[$past(lineEvtId)]);

  assert_sgi_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (swReqValid && (int'(swReqId) < SGI_CNT)) |=> pendingVec[$past(swReqId)]);

  assert_set_pend_R5: assert property (@(posedge clk) disable iff (!rstN)
    (setPendValid && !(lineEvtValid && !lineEvtLevel))
      |=> ((pendingVec & $past(setPendMask)) == $past(setPendMask)));

  assert_ack_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> activeVec[$past(ackId)]);

  assert_deact_R9: assert property (@(posedge clk) disable iff (!rstN)
    (deactValid && !(ackValid && (ackId == deactId))) |=> !activeVec[$past(deactId)]);

  assert_any_needs_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    anyPending |-> (|(pendingVec & ~activeVec)));
endmodule

bind irq_pend_tracker irq_pend_chk u_chk (
  .clk(clk), .rstN(rstN),
  .lineEvtValid(lineEvtValid), .lineEvtId(lineEvtId), .lineEvtLevel(lineEvtLevel),
  .swReqValid(swReqValid), .swReqId(swReqId),
  .setPendValid(setPendValid), .setPendMask(setPendMask),
  .ackValid(ackValid), .ackId(ackId),
  .deactValid(deactValid), .deactId(deactId),
  .pendingVec(pendingVec), .activeVec(activeVec), .anyPending(anyPending)
);

// File: tb/irq_pend_tracker_tb.sv
module irq_pend_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineEvtValid, lineEvtLevel, swReqValid, setPendValid, clrPendValid;
  logic ackValid, deactValid, cfgWrValid, cfgWrAddr;
  logic [4:0] lineEvtId, swReqId, ackId, deactId;
  logic [31:0] setPendMask, clrPendMask, cfgWrData;
  logic [31:0] pendingVec, activeVec;
  logic anyPending;

  // Model state built from the requirements
  logic [31:0] mP = '0, mA = '0, mE = '0, mT = '0, mF = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_tracker u_dut (
    .clk(clk), .rstN(rstN),
    .lineEvtValid(lineEvtValid), .lineEvtId(lineEvtId), .lineEvtLevel(lineEvtLevel),
    .swReqValid(swReqValid), .swReqId(swReqId),
    .setPendValid(setPendValid), .setPendMask(setPendMask),
    .clrPendValid(clrPendValid), .clrPendMask(clrPendMask),
    .ackValid(ackValid), .ackId(ackId),
    .deactValid(deactValid), .deactId(deactId),
    .cfgWrValid(cfgWrValid), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .pendingVec(pendingVec), .activeVec(activeVec), .anyPending(anyPending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lineEvtValid = 0; lineEvtLevel = 0; lineEvtId = '0;
    swReqValid = 0; swReqId = '0;
    setPendValid = 0; setPendMask = '0;
    clrPendValid = 0; clrPendMask = '0;
    ackValid = 0; ackId = '0; deactValid = 0; deactId = '0;
    cfgWrValid = 0; cfgWrAddr = 0; cfgWrData = '0;
  endtask

  // Next model state from the present inputs (R2..R12 ordering)
  task automatic mdlStep();
    logic [31:0] edgeLike, act, dea, clr, set, up, dn, sgi;
    edgeLike = ~mT | mF;
    act = ackValid ? (32'd1 << ackId) : '0;
    dea = deactValid ? (32'd1 << deactId) : '0;
    clr = clrPendValid ? clrPendMask : '0;
    set = setPendValid ? setPendMask : '0;
    up  = (lineEvtValid && lineEvtLevel && lineEvtId >= 16) ? (32'd1 << lineEvtId) : '0;
    dn  = (lineEvtValid && !lineEvtLevel && lineEvtId >= 16) ? (32'd1 << lineEvtId) : '0;
    sgi = (swReqValid && swReqId < 16) ? (32'd1 << swReqId) : '0;
    mP = mP & ~(act & edgeLike);
    mP = mP & ~(clr & edgeLike);
    mP = mP | set;  mF = mF | set;
    mP = mP | up | sgi;  mF = mF & ~(up | sgi);
    mP = mP & ~(dn & mT);
    mA = (mA & ~dea) | act;
    if (cfgWrValid && !cfgWrAddr) mE = cfgWrData;
    if (cfgWrValid &&  cfgWrAddr) mT = cfgWrData & 32'hFFFF_0000;
  endtask

  task automatic tick();
    mdlStep();
    @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] bitv(input logic b);
    return {31'b0, b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pending after reset", pendingVec, '0);
    chk("R1 active after reset", activeVec, '0);
    chk("R1 anyPending after reset", bitv(anyPending), 0);

    // enable all; request level on all (SGI bits must stay edge)
    cfgWrValid = 1; cfgWrAddr = 0; cfgWrData = '1; tick();
    cfgWrValid = 1; cfgWrAddr = 1; cfgWrData = '1; tick();

    lineEvtValid = 1; lineEvtLevel = 1; lineEvtId = 20; tick();
    chk("R2 line assert sets pending", bitv(pendingVec[20]), 1);
    chk("R11 anyPending with enabled pending", bitv(anyPending), 1);

    clrPendValid = 1; clrPendMask = 32'd1 << 20; tick();
    chk("R6 clear ignored on level line-driven", bitv(pendingVec[20]), 1);

    ackValid = 1; ackId = 20; tick();
    chk("R7 ack sets active", bitv(activeVec[20]), 1);
    chk("R7 ack keeps level pending", bitv(pendingVec[20]), 1);
    chk("R11 anyPending low when active", bitv(anyPending), 0);

    lineEvtValid = 1; lineEvtLevel = 0; lineEvtId = 20; tick();
    chk("R8 deassert clears level pending", bitv(pendingVec[20]), 0);

    deactValid = 1; deactId = 20; tick();
    chk("R9 deactivate clears active", bitv(activeVec[20]), 0);

    lineEvtValid = 1; lineEvtLevel = 1; lineEvtId = 5; tick();
    chk("R3 line event in SGI range rejected", pendingVec, '0);

    swReqValid = 1; swReqId = 21; tick();
    chk("R4 software request above 15 ignored", pendingVec, '0);
    swReqValid = 1; swReqId = 5; tick();
    chk("R4 software request sets pending", bitv(pendingVec[5]), 1);

    ackValid = 1; ackId = 5; tick();
    chk("R12 SGI trigger forced edge, ack clears", bitv(pendingVec[5]), 0);
    deactValid = 1; deactId = 5; tick();

    setPendValid = 1; setPendMask = 32'd1 << 22; tick();
    chk("R5 set-pending sets pending", bitv(pendingVec[22]), 1);
    clrPendValid = 1; clrPendMask = 32'd1 << 22; tick();
    chk("R6 clear works on software-set level", bitv(pendingVec[22]), 0);

    setPendValid = 1; setPendMask = 32'd1 << 22; tick();
    ackValid = 1; ackId = 22; tick();
    chk("R7 ack clears software-set level pending", bitv(pendingVec[22]), 0);
    deactValid = 1; deactId = 22; tick();

    cfgWrValid = 1; cfgWrAddr = 1; cfgWrData = 32'hFF00_0000; tick();
    lineEvtValid = 1; lineEvtLevel = 1; lineEvtId = 17; tick();
    lineEvtValid = 1; lineEvtLevel = 0; lineEvtId = 17; tick();
    chk("R8 deassert ignored on edge", bitv(pendingVec[17]), 1);
    clrPendValid = 1; clrPendMask = 32'd1 << 17; tick();
    chk("R6 clear works on edge", bitv(pendingVec[17]), 0);

    setPendValid = 1; setPendMask = 32'd1 << 18;
    clrPendValid = 1; clrPendMask = 32'd1 << 18; tick();
    chk("R10 set beats clear", bitv(pendingVec[18]), 1);
    ackValid = 1; ackId = 19; lineEvtValid = 1; lineEvtLevel = 1; lineEvtId = 19; tick();
    chk("R10 line beats ack on pending", bitv(pendingVec[19]), 1);
    ackValid = 1; ackId = 19; deactValid = 1; deactId = 19; tick();
    chk("R9 ack wins over deactivate", bitv(activeVec[19]), 1);
    chk("R10 directed pending state", pendingVec, mP);

    // Constrained random against the model
    for (int n = 0; n < RAND_CYCLES; n++) begin
      lineEvtValid = ($urandom % 3) == 0; lineEvtLevel = $urandom; lineEvtId = $urandom;
      swReqValid = ($urandom % 4) == 0; swReqId = $urandom;
      setPendValid = ($urandom % 6) == 0; setPendMask = $urandom & $urandom;
      clrPendValid = ($urandom % 5) == 0; clrPendMask = $urandom;
      ackValid = ($urandom % 4) == 0; ackId = $urandom;
      deactValid = ($urandom % 4) == 0; deactId = $urandom;
      cfgWrValid = ($urandom % 40) == 0; cfgWrAddr = $urandom; cfgWrData = $urandom;
      tick();
      chk("R10 random pending", pendingVec, mP);
      chk("R9 random active", activeVec, mA);
      chk("R11 random anyPending", bitv(anyPending), bitv(|(mP & mE & ~mA)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
  end
endmodule